// File: doc/BRIEF.md
# Outstanding-Burst Flush Engine

This block sits beside a bus master whose AXI3-style port cannot be reset. It watches every read-address, read-data, write-address and write-data handshake on that port. From them it keeps its own tally of read beats still owed by the slave and write beats the master still has to send. It also keeps an in-order record of the ID and length of every posted write burst.

When the enclosing design asks for an abort, the engine goes busy and takes over two parts of the port. It holds read-ready high, which accepts and drops every read beat that is still owed. It also presents filler write beats that carry the ID of the oldest unfinished burst, with last set on the final beat of each burst. It keeps doing this until nothing is outstanding, then leaves busy and pulses done. The enclosing design routes the override signals onto the port while busy is high.

A dirty flag tells the caller whether an abort is needed at all. A sticky mismatch flag records an abort that began while the port's own fill-level counters read empty but the engine's tallies did not. Filler write beats follow valid/ready rules: once valid is presented, valid, ID and last hold until the slave's ready is seen high at a clock edge. Reset clears only the abort control. The tallies and the burst record keep their contents, because bursts already in flight still have to be drained.

Top module: `axi_flush_engine`

## Requirements
- R1: After reset, busy, done and mismatch are low. The override outputs flush_r_ready, flush_w_valid, flush_w_last and flush_w_id are all zero.
- R2: A read-address handshake adds len+1 to the read tally, where len is the 4-bit burst length field, so a burst has 1 to 16 beats. A read-data handshake (r_valid and r_ready) subtracts one.
- R3: An abort_req sampled high at a clock edge, while not in reset and not busy, raises busy from that edge. While busy, flush_r_ready is high.
- R4: rst leaves the read tally, the write tally and the burst record unchanged. An abort_req sampled during rst has no effect.
- R5: When an abort is accepted, mismatch is set from that edge if the read tally is non-zero while rd_fill is zero, or if the write tally is non-zero while wr_fill is zero. Once set, mismatch stays high until rst.
- R6: On the first clock edge at which busy is high and both tallies are zero, busy falls and done rises. done lasts exactly one cycle.
- R7: dirty is high exactly when either tally is non-zero. It follows a handshake by one clock edge.
- R8: Each write-address handshake appends its ID and length to an in-order record of QDEPTH entries (32 by default). An entry is removed by the write-data handshake that completes its burst, whether the master or the engine drives that beat. A write-data handshake subtracts one from the write tally, and a write-address handshake adds len+1.
- R9: While busy and a write burst is unfinished, flush_w_valid is high and flush_w_id is the ID of the oldest unfinished burst. flush_w_last is high on that burst's final beat. The beats continue the burst from the point where the master left off.
- R10: While not busy, flush_r_ready, flush_w_valid and flush_w_last are low and flush_w_id is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the abort control only |
| abort_req | input | 1 | Request to flush the port |
| ar_valid | input | 1 | Observed read-address valid |
| ar_ready | input | 1 | Observed read-address ready |
| ar_len | input | 4 | Observed read burst length minus one |
| r_valid | input | 1 | Observed read-data valid |
| r_ready | input | 1 | Read-data ready as seen on the port (after the override multiplexer) |
| aw_valid | input | 1 | Observed write-address valid |
| aw_ready | input | 1 | Observed write-address ready |
| aw_id | input | ID_W | Observed write-address ID |
| aw_len | input | 4 | Observed write burst length minus one |
| w_valid | input | 1 | Write-data valid as seen on the port (after the override multiplexer) |
| w_ready | input | 1 | Observed write-data ready |
| rd_fill | input | LVL_W | The port's read fill level |
| wr_fill | input | LVL_W | The port's write fill level |
| busy | output | 1 | Abort in progress; selects the override outputs |
| done | output | 1 | One-cycle pulse when the flush completes |
| dirty | output | 1 | Some transaction is outstanding |
| mismatch | output | 1 | Sticky fill-level disagreement flag |
| flush_r_ready | output | 1 | Override read-data ready |
| flush_w_valid | output | 1 | Override write-data valid |
| flush_w_id | output | ID_W | Override write-data ID |
| flush_w_last | output | 1 | Override write-data last |

## Verification
Handshakes are counted on the clock edge that completes them, so dirty and the override outputs change one edge after the handshake. busy and mismatch change on the edge that samples abort_req. done and the fall of busy come one edge after the first busy cycle with empty tallies. Stimulus is applied on the falling clock edge, and port activity is recorded just before each rising edge, so every check reads a value that has already settled for that cycle. A scoreboard lists the ID and last flag of every write beat that each posted burst should carry. Each write handshake removes one entry, and the entry is compared with the filler outputs whenever the engine drives the beat.

// File: rtl/flush_pkg.sv
package flush_pkg;
  localparam int BURST_LEN_W = 4;
  typedef logic [BURST_LEN_W-1:0] blen_t;
  typedef enum logic {FE_WATCH, FE_FLUSH} fe_mode_t;
endpackage

// File: rtl/beat_tally.sv
module beat_tally
  import flush_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  blen_t            add_len,
  input  logic             sub_en,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // never cleared by rst: beats in flight must still be drained
  logic [CNT_W-1:0] cnt_q = '0;
  logic [CNT_W-1:0] add_v;

  always_comb add_v = add_en ? (CNT_W'(add_len) + ONE) : '0;

  always_ff @(posedge clk) begin
    cnt_q <= cnt_q + add_v - (sub_en ? ONE : '0);
  end

  assign count = cnt_q;

  // a beat may only leave when one is owed (R2)
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
    sub_en |-> (cnt_q != '0 || add_en));
endmodule

// File: rtl/wr_burst_queue.sv
module wr_burst_queue
  import flush_pkg::*;
#(
  parameter int ID_W  = 6,
  parameter int DEPTH = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [ID_W-1:0] push_id,
  input  blen_t           push_len,
  input  logic            beat,
  output logic [ID_W-1:0] head_id,
  output logic            head_last,
  output logic            empty
);
  localparam int AW = $clog2(DEPTH);

  logic [ID_W-1:0] id_mem  [DEPTH];
  blen_t           len_mem [DEPTH];
  logic [AW:0]     wp_q = '0;
  logic [AW:0]     rp_q = '0;
  blen_t           beat_q = '0;
  logic            full, pop;

  assign empty     = (wp_q == rp_q);
  assign full      = (wp_q[AW-1:0] == rp_q[AW-1:0]) && (wp_q[AW] != rp_q[AW]);
  assign head_id   = id_mem[rp_q[AW-1:0]];
  assign head_last = (beat_q == len_mem[rp_q[AW-1:0]]);
  assign pop       = beat && head_last && !empty;

  always_ff @(posedge clk) begin
    if (push) begin
      id_mem[wp_q[AW-1:0]]  <= push_id;
      len_mem[wp_q[AW-1:0]] <= push_len;
      wp_q <= wp_q + 1'b1;
    end
    if (pop) rp_q <= rp_q + 1'b1;
    if (beat) beat_q <= pop ? '0 : beat_q + 1'b1;
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  p_beat_has_burst_r8: assert property (@(posedge clk) disable iff (rst)
    beat |-> !empty);
endmodule

// File: rtl/axi_flush_engine.sv
module axi_flush_engine
  import flush_pkg::*;
#(
  parameter int ID_W   = 6,
  parameter int CNT_W  = 10,
  parameter int QDEPTH = 32,
  parameter int LVL_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort_req,
  input  logic             ar_valid,
  input  logic             ar_ready,
  input  logic [3:0]       ar_len,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic             aw_valid,
  input  logic             aw_ready,
  input  logic [ID_W-1:0]  aw_id,
  input  logic [3:0]       aw_len,
  input  logic             w_valid,
  input  logic             w_ready,
  input  logic [LVL_W-1:0] rd_fill,
  input  logic [LVL_W-1:0] wr_fill,
  output logic             busy,
  output logic             done,
  output logic             dirty,
  output logic             mismatch,
  output logic             flush_r_ready,
  output logic             flush_w_valid,
  output logic [ID_W-1:0]  flush_w_id,
  output logic             flush_w_last
);
  localparam int NCH = 2; // 0: read side, 1: write side

  logic [NCH-1:0]   t_add, t_sub, t_live;
  blen_t            t_len [NCH];
  logic [CNT_W-1:0] t_cnt [NCH];

  assign t_add[0] = ar_valid && ar_ready;
  assign t_len[0] = ar_len;
  assign t_sub[0] = r_valid && r_ready;
  assign t_add[1] = aw_valid && aw_ready;
  assign t_len[1] = aw_len;
  assign t_sub[1] = w_valid && w_ready;

  for (genvar g = 0; g < NCH; g++) begin : g_tally
    beat_tally #(.CNT_W(CNT_W)) u_tally (
      .clk     (clk),
      .rst     (rst),
      .add_en  (t_add[g]),
      .add_len (t_len[g]),
      .sub_en  (t_sub[g]),
      .count   (t_cnt[g])
    );
    assign t_live[g] = (t_cnt[g] != '0);
  end

  logic [ID_W-1:0] q_head_id;
  logic            q_head_last, q_empty;

  wr_burst_queue #(.ID_W(ID_W), .DEPTH(QDEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (t_add[1]),
    .push_id   (aw_id),
    .push_len  (aw_len),
    .beat      (t_sub[1]),
    .head_id   (q_head_id),
    .head_last (q_head_last),
    .empty     (q_empty)
  );

  fe_mode_t mode_q;
  logic     done_q, mism_q, fill_disagree;

  assign dirty = |t_live;
  assign fill_disagree = (t_live[0] && rd_fill == '0) || (t_live[1] && wr_fill == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= FE_WATCH;
      done_q <= 1'b0;
      mism_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (mode_q)
        FE_WATCH: if (abort_req) begin
          mode_q <= FE_FLUSH;
          if (fill_disagree) mism_q <= 1'b1;
        end
        FE_FLUSH: if (!dirty) begin
          mode_q <= FE_WATCH;
          done_q <= 1'b1;
        end
        default: mode_q <= FE_WATCH;
      endcase
    end
  end

  assign busy          = (mode_q == FE_FLUSH);
  assign done          = done_q;
  assign mismatch      = mism_q;
  assign flush_r_ready = busy;
  assign flush_w_valid = busy && !q_empty;
  assign flush_w_id    = flush_w_valid ? q_head_id : '0;
  assign flush_w_last  = flush_w_valid && q_head_last;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_clean_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !dirty));
  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!flush_r_ready && !flush_w_valid && !flush_w_last && flush_w_id == '0));
  p_hold_valid_r9: assert property (@(posedge clk) disable iff (rst)
    (flush_w_valid && !w_ready) |=> (flush_w_valid && $stable(flush_w_id)));
  p_mismatch_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> mismatch);
  p_queue_tracks_r8: assert property (@(posedge clk) disable iff (rst)
    q_empty |-> !t_live[1]);
endmodule

// File: tb/axi_flush_engine_tb.sv
module axi_flush_engine_tb;
  localparam int ID_W = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, abort_req = 1'b0;
  logic ar_valid = 1'b0, aw_valid = 1'b0;
  logic ar_ready = 1'b1, aw_ready = 1'b1;
  logic [3:0] ar_len = '0, aw_len = '0;
  logic [ID_W-1:0] aw_id = '0;
  logic r_valid = 1'b0, w_ready = 1'b0;
  logic m_r_ready = 1'b0, m_w_valid = 1'b0;
  logic [7:0] rd_fill = 8'd5, wr_fill = 8'd5;
  logic busy, done, dirty, mismatch, flush_r_ready, flush_w_valid, flush_w_last;
  logic [ID_W-1:0] flush_w_id;
  logic r_ready_bus, w_valid_bus;

  assign r_ready_bus = busy ? flush_r_ready : m_r_ready;
  assign w_valid_bus = busy ? flush_w_valid : m_w_valid;

  axi_flush_engine #(.ID_W(ID_W)) u_dut (
    .clk(clk), .rst(rst), .abort_req(abort_req),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_len(ar_len),
    .r_valid(r_valid), .r_ready(r_ready_bus),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len),
    .w_valid(w_valid_bus), .w_ready(w_ready),
    .rd_fill(rd_fill), .wr_fill(wr_fill),
    .busy(busy), .done(done), .dirty(dirty), .mismatch(mismatch),
    .flush_r_ready(flush_r_ready), .flush_w_valid(flush_w_valid),
    .flush_w_id(flush_w_id), .flush_w_last(flush_w_last)
  );

  int checks = 0, errors = 0;
  int s_r_rem = 0, r_taken = 0, w_hs = 0, fill_seen = 0, pat = 0;
  int exp_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // slave side: drives r_valid / w_ready on the falling edge
  always @(negedge clk) begin
    pat++;
    r_valid <= (s_r_rem > 0) && (pat % 4 != 2);
    w_ready <= (pat % 3 != 1);
  end

  // monitor: records handshakes just before the rising edge
  always @(negedge clk) begin
    #2;
    if (ar_valid && ar_ready) s_r_rem += int'(ar_len) + 1;
    if (r_valid && r_ready_bus) begin s_r_rem--; r_taken++; end
    if (aw_valid && aw_ready)
      for (int j = 0; j <= int'(aw_len); j++) exp_q.push_back(int'(aw_id) * 2 + (j == int'(aw_len) ? 1 : 0));
    if (w_valid_bus && w_ready) begin
      w_hs++;
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected write beat", 1, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        if (busy) begin
          fill_seen++;
          check(flush_w_id == ID_W'(e / 2), "R9 filler id", int'(flush_w_id), e / 2);
          check(flush_w_last == e[0], "R9 filler last", int'(flush_w_last), e % 2);
        end
      end
    end
  end

  task automatic issue_ar(input int len);
    @(negedge clk); ar_valid = 1'b1; ar_len = 4'(len);
    @(negedge clk); ar_valid = 1'b0;
  endtask

  task automatic issue_aw(input int id, input int len);
    @(negedge clk); aw_valid = 1'b1; aw_id = ID_W'(id); aw_len = 4'(len);
    @(negedge clk); aw_valid = 1'b0;
  endtask

  task automatic master_w(input int n);
    int target;
    target = w_hs + n;
    @(negedge clk); m_w_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (w_hs >= target) break;
    end
    m_w_valid = 1'b0;
  endtask

  task automatic master_r_drain();
    @(negedge clk); m_r_ready = 1'b1;
    while (s_r_rem > 0) @(negedge clk);
    m_r_ready = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort_req = 1'b1;
    @(negedge clk); abort_req = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  initial begin
    bit seen;
    int r0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R10 reset state
    check(!busy && !done && !mismatch, "R1 reset flags", int'({busy, done, mismatch}), 0);
    check(!flush_r_ready && !flush_w_valid && !flush_w_last && flush_w_id == 0,
          "R10 overrides idle", int'(flush_w_id), 0);
    check(!dirty, "R7 clean at start", int'(dirty), 0);

    // R2 / R7 read tracking in normal traffic
    issue_ar(3);
    check(dirty, "R7 dirty after read address", int'(dirty), 1);
    master_r_drain();
    check(!dirty, "R2 read tally back to zero", int'(dirty), 0);

    // R8 write burst leaves the record when the master completes it
    issue_aw(5, 1);
    check(dirty, "R7 dirty after write address", int'(dirty), 1);
    master_w(2);
    check(!dirty, "R8 write burst completed by master", int'(dirty), 0);

    // R3 / R9 abort with reads owed and a partial write
    issue_ar(2);
    issue_ar(0);
    issue_aw(3, 2);
    issue_aw(7, 0);
    issue_aw(9, 3);
    master_w(1);
    r0 = r_taken;
    fill_seen = 0;
    pulse_abort();
    check(busy, "R3 busy after abort", int'(busy), 1);
    check(flush_r_ready, "R3 read ready held while busy", int'(flush_r_ready), 1);
    check(flush_w_valid && flush_w_id == 3, "R9 first filler id", int'(flush_w_id), 3);
    wait_done(seen);
    check(seen, "R6 done seen after flush", int'(seen), 1);
    check(!busy, "R6 busy falls with done", int'(busy), 0);
    check(r_taken - r0 == 4, "R3 owed read beats drained", r_taken - r0, 4);
    check(fill_seen == 7, "R9 filler beat count", fill_seen, 7);
    check(exp_q.size() == 0, "R8 record emptied", exp_q.size(), 0);
    check(!mismatch, "R5 no mismatch with live fill levels", int'(mismatch), 0);
    @(negedge clk);
    check(!done, "R6 done lasts one cycle", int'(done), 0);
    check(!flush_w_valid && !flush_r_ready, "R10 overrides idle after flush",
          int'({flush_w_valid, flush_r_ready}), 0);

    // R6 abort on a clean port
    pulse_abort();
    check(busy && !done, "R6 clean abort first cycle", int'({busy, done}), 2);
    @(negedge clk);
    check(done && !busy, "R6 clean abort done", int'({busy, done}), 1);
    @(negedge clk);
    check(!done, "R6 clean abort pulse ends", int'(done), 0);

    // R5 mismatch when the fill level reads empty
    issue_ar(1);
    rd_fill = 8'd0;
    pulse_abort();
    check(mismatch, "R5 mismatch set at abort", int'(mismatch), 1);
    wait_done(seen);
    check(seen, "R6 done after mismatch flush", int'(seen), 1);
    @(negedge clk);
    check(mismatch, "R5 mismatch sticky", int'(mismatch), 1);
    rd_fill = 8'd5;

    // R4 reset keeps tallies and ignores abort
    issue_ar(0);
    @(negedge clk); rst = 1'b1; abort_req = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy, "R4 abort ignored in reset", int'(busy), 0);
    check(dirty, "R4 tally survives reset", int'(dirty), 1);
    check(!mismatch, "R5 mismatch cleared by reset", int'(mismatch), 0);
    rst = 1'b0; abort_req = 1'b0;
    @(negedge clk);
    check(dirty && !busy, "R4 tally kept after reset", int'({dirty, busy}), 2);
    r0 = r_taken;
    pulse_abort();
    wait_done(seen);
    check(seen && (r_taken - r0 == 1), "R4 kept beat drained", r_taken - r0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule